// File: doc/BRIEF.md
# Qualified Predicate Compare Unit

This block evaluates one compare per clock and writes its outcome into a pair of one-bit predicate registers. Each operation carries two 64-bit operands with their poison flags, a relation code, a write-type code, a qualifier index and two target indices. The relation is either an arithmetic comparison of the operands or, in test-bit mode, the value of one selected bit of operand A. The write type controls how the relation and the qualifier combine into the targets. Besides the plain and unconditional forms, there are wired AND, wired OR and OR/AND-complement forms, so that several compares can fold into one predicate pair in the same schedule slot.

The unit holds a file of 64 predicates. Entry 0 is hardwired to true, so it serves as the qualifier for operations that must always execute. A write lands at the clock edge and is visible to the next operation, including when that operation uses the written entry as its qualifier. The full predicate file is brought out as a vector so that downstream logic can read any entry.

Top module: `qpc_unit`

## Requirements
- R1: After reset every predicate reads 0 except entry 0, which reads 1.
- R2: relCode selects the relation: 0 equal, 1 not-equal, 2 signed less-than (A < B), 3 unsigned less-than (A < B).
- R3: cmpType 0 (plain): when the qualifier is 1, target 1 takes the relation and target 2 its complement; when the qualifier is 0, both targets keep their values.
- R4: cmpType 1 (unconditional): both targets are always written, target 1 with qualifier AND relation and target 2 with qualifier AND NOT relation.
- R5: cmpType 2 (wired AND): both targets are cleared only when the qualifier is 1 and the relation is 0. In every other case both targets keep their values.
- R6: cmpType 3 (wired OR): both targets are set only when the qualifier is 1 and the relation is 1. In every other case both targets keep their values.
- R7: cmpType 4 (OR/AND-complement): when the qualifier is 1 and the relation is 1, target 1 is set and target 2 is cleared. In every other case both targets keep their values.
- R8: A poisoned source makes the compare write 0 in place of the relation result. With the qualifier at 1, all five types clear both targets. With the qualifier at 0, types 0, 2, 3 and 4 leave both targets unchanged and type 1 clears both.
- R9: With testBit at 1, the relation is bit bitSel of operand A and relCode is ignored. Only operand A's poison flag counts in this mode.
- R10: Entry 0 always reads 1. Writes that target it have no effect.
- R11: When both target indices name the same entry, the value meant for target 1 is the one stored.
- R12: When opValid is 0, or when cmpType is 5, 6 or 7, no predicate changes.
- R13: A write takes effect at the clock edge. The next operation sees it, including as its qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| srcA | input | 64 | Operand A |
| srcAPoison | input | 1 | Poison flag of operand A |
| srcB | input | 64 | Operand B |
| srcBPoison | input | 1 | Poison flag of operand B |
| relCode | input | 2 | Relation select (R2) |
| cmpType | input | 3 | Write-type select (R3 to R7) |
| testBit | input | 1 | Use a bit of operand A as the relation |
| bitSel | input | 6 | Bit index into operand A for test-bit mode |
| qualIdx | input | 6 | Qualifying predicate index |
| tgtIdx1 | input | 6 | First target predicate index |
| tgtIdx2 | input | 6 | Second target predicate index |
| predState | output | 64 | Current contents of the predicate file |

## Verification
The properties only assume that the inputs are known whenever opValid is high. They read the qualifier from the design's own predState output, so a qualifier produced by the immediately preceding write is covered. Properties that name a target skip entry 0, because that entry ignores writes. The stimulus drives every input to a defined value on every cycle. It confines its indices to the low entries, so qualifiers hit freshly written predicates, targets collide, and entry 0 shows up as a target often. It also forces equal operands and poison flags often enough that each write type sees both relation outcomes with and without poison.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    REL_EQ  = 2'd0,
    REL_NE  = 2'd1,
    REL_SLT = 2'd2,
    REL_ULT = 2'd3
  } relCode_e;

  typedef enum logic [2:0] {
    WT_PLAIN   = 3'd0,
    WT_UNCOND  = 3'd1,
    WT_AND     = 3'd2,
    WT_OR      = 3'd3,
    WT_ORANDCM = 3'd4
  } writeType_e;

  // Strobes from control to datapath: one write enable and value per target.
  typedef struct packed {
    logic wrFirst;
    logic wrSecond;
    logic valFirst;
    logic valSecond;
  } predStrobe_t;

endpackage

// File: rtl/qpc_relation.sv
module qpc_relation #(
  parameter int DATA_W = 64,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        relSel,
  input  logic              bitMode,
  input  logic [SEL_W-1:0]  bitSel,
  output logic              relOut
);
  import qpc_pkg::*;

  logic arithRel;

  always_comb begin
    unique case (relCode_e'(relSel))
      REL_EQ:  arithRel = (opA == opB);
      REL_NE:  arithRel = (opA != opB);
      REL_SLT: arithRel = ($signed(opA) < $signed(opB));
      default: arithRel = (opA < opB);
    endcase
  end

  assign relOut = bitMode ? opA[bitSel] : arithRel;

endmodule

// File: rtl/qpc_predfile.sv
module qpc_predfile #(
  parameter int PRED_N = 64,
  localparam int IDX_W = $clog2(PRED_N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  qpc_pkg::predStrobe_t strobe,
  input  logic [IDX_W-1:0]    tgtFirst,
  input  logic [IDX_W-1:0]    tgtSecond,
  input  logic [IDX_W-1:0]    qualIdx,
  output logic                qualVal,
  output logic [PRED_N-1:0]   predBits
);

  for (genvar i = 0; i < PRED_N; i++) begin : g_entry
    if (i == 0) begin : g_hard
      assign predBits[i] = 1'b1;
    end else begin : g_reg
      logic hitFirst;
      logic hitSecond;
      assign hitFirst  = strobe.wrFirst  && (tgtFirst  == IDX_W'(i));
      assign hitSecond = strobe.wrSecond && (tgtSecond == IDX_W'(i));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          predBits[i] <= 1'b0;
        end else if (hitFirst) begin
          predBits[i] <= strobe.valFirst;
        end else if (hitSecond) begin
          predBits[i] <= strobe.valSecond;
        end
      end
    end
  end

  assign qualVal = predBits[qualIdx];

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath #(
  parameter int DATA_W = 64,
  parameter int PRED_N = 64,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int IDX_W = $clog2(PRED_N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    srcA,
  input  logic                 srcAPoison,
  input  logic [DATA_W-1:0]    srcB,
  input  logic                 srcBPoison,
  input  logic [1:0]           relCode,
  input  logic                 testBit,
  input  logic [SEL_W-1:0]     bitSel,
  input  logic [IDX_W-1:0]     qualIdx,
  input  logic [IDX_W-1:0]     tgtIdx1,
  input  logic [IDX_W-1:0]     tgtIdx2,
  input  qpc_pkg::predStrobe_t strobe,
  output logic                 relBit,
  output logic                 poisonHit,
  output logic                 qualVal,
  output logic [PRED_N-1:0]    predState
);

  // Operand B plays no part in a bit test, so its poison is masked there.
  assign poisonHit = srcAPoison | (~testBit & srcBPoison);

  qpc_relation #(.DATA_W(DATA_W)) uRel (
    .opA     (srcA),
    .opB     (srcB),
    .relSel  (relCode),
    .bitMode (testBit),
    .bitSel  (bitSel),
    .relOut  (relBit)
  );

  qpc_predfile #(.PRED_N(PRED_N)) uFile (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .tgtFirst  (tgtIdx1),
    .tgtSecond (tgtIdx2),
    .qualIdx   (qualIdx),
    .qualVal   (qualVal),
    .predBits  (predState)
  );

endmodule

// File: rtl/qpc_control.sv
module qpc_control (
  input  logic                 opValid,
  input  logic [2:0]           cmpType,
  input  logic                 relBit,
  input  logic                 poisonHit,
  input  logic                 qualVal,
  output qpc_pkg::predStrobe_t strobe
);
  import qpc_pkg::*;

  logic goodRel;
  logic badRel;

  assign goodRel = ~poisonHit & relBit;
  assign badRel  = ~poisonHit & ~relBit;

  always_comb begin
    strobe = '0;
    if (opValid) begin
      unique case (cmpType)
        WT_PLAIN: begin
          strobe.wrFirst   = qualVal;
          strobe.wrSecond  = qualVal;
          strobe.valFirst  = goodRel;
          strobe.valSecond = badRel;
        end
        WT_UNCOND: begin
          strobe.wrFirst   = 1'b1;
          strobe.wrSecond  = 1'b1;
          strobe.valFirst  = qualVal & goodRel;
          strobe.valSecond = qualVal & badRel;
        end
        WT_AND: begin
          strobe.wrFirst   = qualVal & ~goodRel;
          strobe.wrSecond  = qualVal & ~goodRel;
        end
        WT_OR: begin
          strobe.wrFirst   = qualVal & (goodRel | poisonHit);
          strobe.wrSecond  = qualVal & (goodRel | poisonHit);
          strobe.valFirst  = goodRel;
          strobe.valSecond = goodRel;
        end
        WT_ORANDCM: begin
          strobe.wrFirst   = qualVal & (goodRel | poisonHit);
          strobe.wrSecond  = qualVal & (goodRel | poisonHit);
          strobe.valFirst  = goodRel;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/qpc_unit.sv
module qpc_unit #(
  parameter int DATA_W = 64,
  parameter int PRED_N = 64,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int IDX_W = $clog2(PRED_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic              srcAPoison,
  input  logic [DATA_W-1:0] srcB,
  input  logic              srcBPoison,
  input  logic [1:0]        relCode,
  input  logic [2:0]        cmpType,
  input  logic              testBit,
  input  logic [SEL_W-1:0]  bitSel,
  input  logic [IDX_W-1:0]  qualIdx,
  input  logic [IDX_W-1:0]  tgtIdx1,
  input  logic [IDX_W-1:0]  tgtIdx2,
  output logic [PRED_N-1:0] predState
);
  import qpc_pkg::*;

  predStrobe_t strobe;
  logic        relBit;
  logic        poisonHit;
  logic        qualVal;

  qpc_control uCtrl (
    .opValid   (opValid),
    .cmpType   (cmpType),
    .relBit    (relBit),
    .poisonHit (poisonHit),
    .qualVal   (qualVal),
    .strobe    (strobe)
  );

  qpc_datapath #(.DATA_W(DATA_W), .PRED_N(PRED_N)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .srcA       (srcA),
    .srcAPoison (srcAPoison),
    .srcB       (srcB),
    .srcBPoison (srcBPoison),
    .relCode    (relCode),
    .testBit    (testBit),
    .bitSel     (bitSel),
    .qualIdx    (qualIdx),
    .tgtIdx1    (tgtIdx1),
    .tgtIdx2    (tgtIdx2),
    .strobe     (strobe),
    .relBit     (relBit),
    .poisonHit  (poisonHit),
    .qualVal    (qualVal),
    .predState  (predState)
  );

endmodule

// File: rtl/qpc_unit_checker.sv
module qpc_unit_checker #(
  parameter int PRED_N = 64,
  localparam int IDX_W = $clog2(PRED_N)
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              srcAPoison,
  input logic              srcBPoison,
  input logic [2:0]        cmpType,
  input logic              testBit,
  input logic [IDX_W-1:0]  qualIdx,
  input logic [IDX_W-1:0]  tgtIdx1,
  input logic [PRED_N-1:0] predState
);

  logic poisoned;
  logic qualNow;
  assign poisoned = srcAPoison | (!testBit & srcBPoison);
  assign qualNow  = predState[qualIdx];

  // R10
  entry_zero_true_chk: assert property (@(posedge clk) disable iff (!rstN)
    predState[0]);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> predState == $past(predState));

  // R4
  uncond_false_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cmpType == 3'd1 && !qualNow && tgtIdx1 != '0)
      |=> !predState[$past(tgtIdx1)]);

  // R5
  and_never_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cmpType == 3'd2) |=> (predState & ~$past(predState)) == '0);

  // R6
  or_never_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cmpType == 3'd3 && !poisoned)
      |=> ($past(predState) & ~predState) == '0);

  // R8
  poison_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cmpType <= 3'd4 && qualNow && poisoned && tgtIdx1 != '0)
      |=> !predState[$past(tgtIdx1)]);

endmodule

bind qpc_unit qpc_unit_checker #(.PRED_N(PRED_N)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .srcAPoison (srcAPoison),
  .srcBPoison (srcBPoison),
  .cmpType    (cmpType),
  .testBit    (testBit),
  .qualIdx    (qualIdx),
  .tgtIdx1    (tgtIdx1),
  .predState  (predState)
);

// File: tb/qpc_unit_test.sv
`timescale 1ns/1ps
module qpc_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [63:0] srcA = '0;
  logic        srcAPoison = 1'b0;
  logic [63:0] srcB = '0;
  logic        srcBPoison = 1'b0;
  logic [1:0]  relCode = '0;
  logic [2:0]  cmpType = '0;
  logic        testBit = 1'b0;
  logic [5:0]  bitSel = '0;
  logic [5:0]  qualIdx = '0;
  logic [5:0]  tgtIdx1 = '0;
  logic [5:0]  tgtIdx2 = '0;
  logic [63:0] predState;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;
  bit  refPred [64];

  always #2 clk = ~clk;

  qpc_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid),
    .srcA(srcA), .srcAPoison(srcAPoison),
    .srcB(srcB), .srcBPoison(srcBPoison),
    .relCode(relCode), .cmpType(cmpType), .testBit(testBit),
    .bitSel(bitSel), .qualIdx(qualIdx), .tgtIdx1(tgtIdx1),
    .tgtIdx2(tgtIdx2), .predState(predState)
  );

  function automatic logic [63:0] refVec();
    logic [63:0] v;
    for (int i = 0; i < 64; i++) v[i] = refPred[i];
    return v;
  endfunction

  task automatic checkVec(string tag);
    checkCnt++;
    if (predState !== refVec()) begin
      failCnt++;
      $display("FAIL %s: predState actual %h expected %h", tag, predState, refVec());
    end
  endtask

  // Behavioural model of one operation, applied to refPred.
  task automatic modelOp(bit v, logic [63:0] a, bit pa, logic [63:0] b, bit pb,
                         int rel, int typ, bit tb, int bs, int q, int t1, int t2);
    bit r, qv, pz, w1, w2, v1, v2;
    if (tb) r = a[bs];
    else if (rel == 0) r = (a == b);
    else if (rel == 1) r = (a != b);
    else if (rel == 2) r = ($signed(a) < $signed(b));
    else r = (a < b);
    qv = refPred[q];
    pz = pa || (!tb && pb);
    if (pz) r = 0;
    w1 = 0; w2 = 0; v1 = 0; v2 = 0;
    if (v) begin
      if (typ == 0 && qv) begin w1 = 1; w2 = 1; v1 = r; v2 = !r && !pz; end
      if (typ == 1) begin w1 = 1; w2 = 1; v1 = qv && r; v2 = qv && !r && !pz; end
      if (typ == 2 && qv && !r) begin w1 = 1; w2 = 1; end
      if (typ == 3 && qv && (r || pz)) begin w1 = 1; w2 = 1; v1 = r; v2 = r; end
      if (typ == 4 && qv && (r || pz)) begin w1 = 1; w2 = 1; v1 = r; v2 = 0; end
    end
    if (w2 && t2 != 0) refPred[t2] = v2;
    if (w1 && t1 != 0) refPred[t1] = v1;
  endtask

  task automatic runOp(string tag, bit v, logic [63:0] a, bit pa, logic [63:0] b, bit pb,
                       int rel, int typ, bit tb, int bs, int q, int t1, int t2);
    opValid = v; srcA = a; srcAPoison = pa; srcB = b; srcBPoison = pb;
    relCode = 2'(rel); cmpType = 3'(typ); testBit = tb; bitSel = 6'(bs);
    qualIdx = 6'(q); tgtIdx1 = 6'(t1); tgtIdx2 = 6'(t2);
    modelOp(v, a, pa, b, pb, rel, typ, tb, bs, q, t1, t2);
    @(posedge clk);
    @(negedge clk);
    checkVec(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) refPred[i] = (i == 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVec("R1 reset");

    // R3 plain compare, qualifier entry 0
    runOp("R3 eq true",  1, 64'd5, 0, 64'd5, 0, 0, 0, 0, 0, 0, 1, 2);
    runOp("R3 ne false", 1, 64'd5, 0, 64'd5, 0, 1, 0, 0, 0, 0, 1, 2);
    runOp("R3 qual off", 1, 64'd5, 0, 64'd5, 0, 0, 0, 0, 0, 3, 1, 2);
    // R2 signed versus unsigned ordering
    runOp("R2 slt", 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 0, 2, 1, 0, 0, 0, 4, 5);
    runOp("R2 ult", 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 0, 3, 1, 0, 0, 0, 4, 5);
    runOp("R2 ult small", 1, 64'd1, 0, 64'd2, 0, 3, 1, 0, 0, 0, 4, 5);
    // R4 unconditional with qualifier 0 clears both
    runOp("R4 qual off", 1, 64'd0, 0, 64'd0, 0, 0, 1, 0, 0, 6, 4, 2);
    // R5 wired AND
    runOp("R5 setup", 1, 64'd1, 0, 64'd1, 0, 0, 3, 0, 0, 0, 7, 8);
    runOp("R5 rel true", 1, 64'd1, 0, 64'd1, 0, 0, 2, 0, 0, 0, 7, 8);
    runOp("R5 qual off", 1, 64'd1, 0, 64'd2, 0, 0, 2, 0, 0, 6, 7, 8);
    runOp("R5 rel false", 1, 64'd1, 0, 64'd2, 0, 0, 2, 0, 0, 0, 7, 8);
    // R6 wired OR
    runOp("R6 rel false", 1, 64'd1, 0, 64'd2, 0, 0, 3, 0, 0, 0, 7, 8);
    runOp("R6 qual off", 1, 64'd1, 0, 64'd1, 0, 0, 3, 0, 0, 6, 7, 8);
    runOp("R6 rel true", 1, 64'd1, 0, 64'd1, 0, 0, 3, 0, 0, 0, 7, 8);
    // R7 OR/AND-complement
    runOp("R7 rel false", 1, 64'd3, 0, 64'd4, 0, 0, 4, 0, 0, 0, 7, 8);
    runOp("R7 rel true", 1, 64'd3, 0, 64'd3, 0, 0, 4, 0, 0, 0, 7, 8);
    // R8 poison
    runOp("R8 setup", 1, 64'd3, 0, 64'd3, 0, 0, 3, 0, 0, 0, 11, 12);
    runOp("R8 or poison", 1, 64'd3, 0, 64'd3, 1, 0, 3, 0, 0, 0, 11, 12);
    runOp("R8 plain poison", 1, 64'd3, 1, 64'd4, 0, 1, 0, 0, 0, 0, 11, 12);
    runOp("R8 qual off", 1, 64'd3, 1, 64'd3, 1, 0, 0, 0, 0, 6, 1, 2);
    // R9 test bit
    runOp("R9 bit63", 1, 64'h8000_0000_0000_0000, 0, 64'd0, 0, 0, 0, 1, 63, 0, 13, 14);
    runOp("R9 bit0 clear", 1, 64'h8000_0000_0000_0000, 0, 64'd0, 0, 1, 0, 1, 0, 0, 13, 14);
    runOp("R9 B poison ignored", 1, 64'h2, 0, 64'd0, 1, 0, 0, 1, 1, 0, 13, 14);
    runOp("R9 A poison", 1, 64'h2, 1, 64'd0, 0, 0, 0, 1, 1, 0, 13, 14);
    // R10 entry 0 immune to writes
    runOp("R10 write zero", 1, 64'd1, 0, 64'd2, 0, 0, 0, 0, 0, 0, 0, 0);
    runOp("R10 unc zero", 1, 64'd1, 0, 64'd1, 0, 0, 1, 0, 0, 6, 0, 15);
    // R11 same target
    runOp("R11 same true", 1, 64'd9, 0, 64'd9, 0, 0, 0, 0, 0, 0, 9, 9);
    runOp("R11 same false", 1, 64'd9, 0, 64'd8, 0, 0, 0, 0, 0, 0, 9, 9);
    // R12 idle and reserved types
    runOp("R12 idle", 0, 64'd9, 0, 64'd8, 0, 1, 1, 0, 0, 0, 9, 10);
    runOp("R12 type5", 1, 64'd9, 0, 64'd8, 0, 1, 5, 0, 0, 0, 9, 10);
    runOp("R12 type7", 1, 64'd9, 0, 64'd9, 0, 0, 7, 0, 0, 0, 9, 10);
    // R13 back-to-back use of a fresh write as qualifier
    runOp("R13 write", 1, 64'd1, 0, 64'd1, 0, 0, 0, 0, 0, 0, 20, 21);
    runOp("R13 use", 1, 64'd1, 0, 64'd1, 0, 0, 0, 0, 0, 20, 22, 23);
    runOp("R13 clear", 1, 64'd1, 0, 64'd2, 0, 0, 0, 0, 0, 0, 20, 21);
    runOp("R13 use off", 1, 64'd1, 0, 64'd1, 0, 1, 1, 0, 0, 20, 22, 23);

    // Mixed stimulus on low indices
    for (int n = 0; n < 600; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom_range(0, 2) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b = {32'h0, $urandom};
      runOp("mixed", ($urandom_range(0, 7) != 0), a, ($urandom_range(0, 7) == 0),
            b, ($urandom_range(0, 7) == 0), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0),
            int'($urandom_range(0, 63)), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule